// File: doc/BRIEF.md
# Memory-Mapped Keyboard Input Port

This peripheral sits on a simple synchronous system bus and hands characters from a keyboard front end to software. A character source presents one byte together with a single-cycle valid strobe. The port latches the byte into a data register and raises a ready flag. Software polls a status register for that flag, or takes an interrupt, and then reads the data register.

Reading the data register clears the ready flag, so software needs no acknowledge write. If a second character arrives before the first is read, the new byte replaces the old one and an overrun flag is raised. A read of the status register clears the overrun flag. An interrupt request output is high while a character waits, provided software has enabled it.

The two registers occupy adjacent bus addresses starting at a base address set by a parameter. A read of any other address leaves the read-data bus undriven.

Top module: `kbd_port`

## Requirements
- R1: After reset the ready, overrun and interrupt-enable flags are clear, `irq` is low and `bus_rdata_oe` is low.
- R2: The status register decodes at BASE_ADDR (default 0x0A00) and the data register at BASE_ADDR+1. A read strobe in cycle t puts the register value on `bus_rdata` with `bus_rdata_oe` high in cycle t+1 only. Status bit 7 is ready, bit 6 is overrun, and bits 5..0 read as zero.
- R3: A cycle with `char_valid` high latches `char_in` into the data register and sets ready.
- R4: A bus read of the data register clears ready at the same clock edge. The read returns the byte held before that edge.
- R5: A read of any address other than the two decoded ones keeps `bus_rdata_oe` low and `bus_rdata` at zero. A write to any other address changes no state.
- R6: When `char_valid` and a data-register read fall in the same cycle, the read returns the old byte, the new byte is latched, ready stays set and overrun is not raised.
- R7: A character that arrives while ready is set and is not read in the same cycle sets overrun (status bit 6). A status read returns overrun and then clears it, except when a new overrun occurs in the same cycle, which keeps it set.
- R8: A write to the status address loads the interrupt enable from bit 0 of `bus_wdata`. `irq` is high exactly when ready and the enable are both set.
- R9: Writes to the data register leave its contents and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| bus_rdata_oe | output | 1 | High while the port drives `bus_rdata` |
| char_in | input | 8 | Character from the source |
| char_valid | input | 1 | One-cycle strobe qualifying `char_in` |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the defaults: ADDR_W of 16 and BASE_ADDR of 0x0A00. With these values it can probe the neighbours 0x09FF and 0x0A02, the address 0x8A00 that differs only in the top bit, and 0x0B01, so any partial decode shows up as a spurious drive. A full 16-bit address also lets it confirm that writes to undecoded locations leave the enable untouched. The same-cycle collisions of a character strobe with a data read and with a status read are driven on purpose, because those orderings decide the overrun and ready outcomes.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;
    parameter int KBD_DATA_W = 8;
    localparam int RDY_BIT = KBD_DATA_W - 1;
    localparam int OVR_BIT = KBD_DATA_W - 2;

    typedef struct packed {
        logic                  ready;
        logic                  ovr;
        logic                  irq_en;
        logic [KBD_DATA_W-1:0] data;
    } kbd_state_t;

    typedef struct packed {
        logic                  oe;
        logic [KBD_DATA_W-1:0] rdata;
    } kbd_rd_t;
endpackage

// File: rtl/kbd_addr_dec.sv
module kbd_addr_dec #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0A00
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              stat_rd,
    output logic              data_rd,
    output logic              stat_wr,
    output logic              data_wr
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

    logic hit_stat, hit_data;

    always_comb begin
        hit_stat = (addr == BASE_ADDR);
        hit_data = (addr == DATA_ADDR);
        stat_rd  = rd & hit_stat;
        data_rd  = rd & hit_data;
        stat_wr  = wr & hit_stat;
        data_wr  = wr & hit_data;
    end
endmodule

// File: rtl/kbd_regs.sv
module kbd_regs
    import kbd_port_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stat_rd,
    input  logic                  data_rd,
    input  logic                  stat_wr,
    input  logic                  data_wr,
    input  logic [KBD_DATA_W-1:0] wdata,
    input  logic [KBD_DATA_W-1:0] char_in,
    input  logic                  char_valid,
    output kbd_state_t            st
);
    kbd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stat_rd) st_d.ovr   = 1'b0;
        if (data_rd) st_d.ready = 1'b0;
        if (char_valid) begin
            if (st_q.ready && !data_rd) st_d.ovr = 1'b1;
            st_d.ready = 1'b1;
            st_d.data  = char_in;
        end
        if (stat_wr) st_d.irq_en = wdata[0];
        // data-register writes fall through with no effect
        if (data_wr) st_d.data = st_d.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;

    AST_DATA_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !char_valid) |=> !st_q.ready); // R4
    AST_CHAR_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> (st_q.ready && st_q.data == $past(char_in))); // R3
    AST_OVERRUN_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && st_q.ready && !data_rd) |=> st_q.ovr); // R7
    AST_DATA_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !char_valid) |=> $stable(st_q.data)); // R9
endmodule

// File: rtl/kbd_rdmux.sv
module kbd_rdmux
    import kbd_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stat_rd,
    input  logic       data_rd,
    input  kbd_state_t st,
    output kbd_rd_t    rd_out
);
    kbd_rd_t rd_d, rd_q;

    always_comb begin
        rd_d = '0;
        if (stat_rd) begin
            rd_d.oe             = 1'b1;
            rd_d.rdata[RDY_BIT] = st.ready;
            rd_d.rdata[OVR_BIT] = st.ovr;
        end else if (data_rd) begin
            rd_d.oe    = 1'b1;
            rd_d.rdata = st.data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_out = rd_q;

    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stat_rd) |-> (rd_q.rdata[OVR_BIT-1:0] == '0)); // R2
endmodule

// File: rtl/kbd_port.sv
module kbd_port
    import kbd_port_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0A00
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [KBD_DATA_W-1:0] bus_wdata,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    output logic [KBD_DATA_W-1:0] bus_rdata,
    output logic                  bus_rdata_oe,
    input  logic [KBD_DATA_W-1:0] char_in,
    input  logic                  char_valid,
    output logic                  irq
);
    logic       stat_rd, data_rd, stat_wr, data_wr;
    kbd_state_t st;
    kbd_rd_t    rd_out;

    kbd_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr    (bus_addr),
        .rd      (bus_rd),
        .wr      (bus_wr),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .stat_wr (stat_wr),
        .data_wr (data_wr)
    );

    kbd_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_rd    (stat_rd),
        .data_rd    (data_rd),
        .stat_wr    (stat_wr),
        .data_wr    (data_wr),
        .wdata      (bus_wdata),
        .char_in    (char_in),
        .char_valid (char_valid),
        .st         (st)
    );

    kbd_rdmux u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .st      (st),
        .rd_out  (rd_out)
    );

    assign bus_rdata    = rd_out.rdata;
    assign bus_rdata_oe = rd_out.oe;
    assign irq          = st.ready & st.irq_en;

    AST_DRIVE_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_oe |-> $past(bus_rd)); // R5
    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata_oe |-> (bus_rdata == '0)); // R5
    AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !bus_wdata[0]) |=> !irq); // R8
endmodule

// File: tb/kbd_port_test.sv
`timescale 1ns/1ps
module kbd_port_test;
    localparam logic [15:0] BASE = 16'h0A00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic        bus_rdata_oe;
    logic [7:0]  char_in = '0;
    logic        char_valid = 1'b0;
    logic        irq;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";

    // reference model state
    logic       m_ready = 0, m_ovr = 0, m_en = 0, m_oe = 0;
    logic [7:0] m_data = 0, m_rdata = 0;

    kbd_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .bus_rdata_oe(bus_rdata_oe), .char_in(char_in), .char_valid(char_valid),
        .irq(irq)
    );

    always #4 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ready <= 0; m_ovr <= 0; m_en <= 0; m_data <= 0; m_oe <= 0; m_rdata <= 0;
        end else begin
            bit hs, hd, ws;
            bit nr, no;
            hs = bus_rd && bus_addr == BASE;
            hd = bus_rd && bus_addr == BASE + 16'd1;
            ws = bus_wr && bus_addr == BASE;
            m_oe    <= hs || hd;
            m_rdata <= hs ? {m_ready, m_ovr, 6'b0} : (hd ? m_data : 8'h00);
            nr = m_ready; no = m_ovr;
            if (hs) no = 0;
            if (hd) nr = 0;
            if (char_valid) begin
                if (m_ready && !hd) no = 1;
                nr = 1;
                m_data <= char_in;
            end
            m_ready <= nr; m_ovr <= no;
            if (ws) m_en <= bus_wdata[0];
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        check(cur_req, "model oe", bus_rdata_oe, m_oe);
        check(cur_req, "model rdata", bus_rdata, m_rdata);
        check(cur_req, "model irq", irq, m_ready && m_en);
    end

    task automatic idle();
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; char_valid = 0;
    endtask

    task automatic rd_expect(logic [15:0] a, bit oe_exp, logic [7:0] exp, string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
        #1;
        check(req, "read oe", bus_rdata_oe, oe_exp);
        check(req, "read data", bus_rdata, exp);
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic send(logic [7:0] c);
        @(negedge clk);
        char_in = c; char_valid = 1;
        @(negedge clk);
        char_valid = 0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", "reset oe", bus_rdata_oe, 0);
        check("R1", "reset irq", irq, 0);
        rst_n = 1;
        idle();
        cur_req = "R1";
        rd_expect(BASE, 1, 8'h00, "R1");

        cur_req = "R3";
        send(8'h41);
        rd_expect(BASE, 1, 8'h80, "R3");
        cur_req = "R2";
        rd_expect(BASE + 16'd1, 1, 8'h41, "R2");
        idle(); #1;
        check("R2", "oe one cycle only", bus_rdata_oe, 0);
        cur_req = "R4";
        rd_expect(BASE, 1, 8'h00, "R4");

        cur_req = "R5";
        send(8'h33);
        rd_expect(16'h09FF, 0, 8'h00, "R5");
        rd_expect(16'h0A02, 0, 8'h00, "R5");
        rd_expect(16'h8A00, 0, 8'h00, "R5");
        rd_expect(16'h0B01, 0, 8'h00, "R5");
        wr(16'h0A02, 8'h01);
        wr(16'h8A00, 8'h01);
        idle(); #1;
        check("R5", "irq after foreign writes", irq, 0);
        rd_expect(BASE + 16'd1, 1, 8'h33, "R5");

        cur_req = "R8";
        wr(BASE, 8'h01);
        idle(); #1;
        check("R8", "irq enabled no char", irq, 0);
        send(8'h5A);
        #1;
        check("R8", "irq with char", irq, 1);
        rd_expect(BASE + 16'd1, 1, 8'h5A, "R8");
        check("R8", "irq after data read", irq, 0);
        wr(BASE, 8'hFE);
        send(8'h11);
        #1;
        check("R8", "irq disabled", irq, 0);

        cur_req = "R9";
        wr(BASE + 16'd1, 8'h55);
        rd_expect(BASE, 1, 8'h80, "R9");
        rd_expect(BASE + 16'd1, 1, 8'h11, "R9");

        cur_req = "R6";
        send(8'h22);
        @(negedge clk);
        bus_addr = BASE + 16'd1; bus_rd = 1; char_in = 8'h77; char_valid = 1;
        @(negedge clk);
        bus_rd = 0; char_valid = 0;
        #1;
        check("R6", "collide read old", bus_rdata, 8'h22);
        rd_expect(BASE, 1, 8'h80, "R6");
        rd_expect(BASE + 16'd1, 1, 8'h77, "R6");

        cur_req = "R7";
        send(8'h01);
        send(8'h02);
        rd_expect(BASE, 1, 8'hC0, "R7");
        rd_expect(BASE, 1, 8'h80, "R7");
        @(negedge clk);
        bus_addr = BASE; bus_rd = 1; char_in = 8'h03; char_valid = 1;
        @(negedge clk);
        bus_rd = 0; char_valid = 0;
        #1;
        check("R7", "status before new overrun", bus_rdata, 8'h80);
        rd_expect(BASE, 1, 8'hC0, "R7");
        rd_expect(BASE + 16'd1, 1, 8'h03, "R7");
        rd_expect(BASE, 1, 8'h00, "R7");

        repeat (3) idle();
        finish_run();
    end
endmodule